// File: doc/BRIEF.md
# Supply-fall supervisor sequencer

This block turns three synchronized supply comparator flags (supply under the warning level, under the minimum operating level, under the battery switchover level) into the processor's power-related controls. A first fall below the warning level raises a one-cycle interrupt request with a fixed vector while execution goes on. A fall below the minimum operating level holds the core in reset and drives the chip enables and the read/write strobe to their inactive high level. A fall below the lowest level also selects the backup battery.

When the supply comes back above the minimum operating level, reset is held for a fixed count of oscillator clocks (21504 by default) before the core may run. The analog comparators, the reference and the battery switch itself are outside the block. The thresholds are taken as ordered, so a lower flag implies all the higher ones.

Top module: `pwr_seq_ctl`

## Requirements
- R1: Each raw flag passes through SYNC_STAGES (default 2) flip-flops; a raw change driven before clock edge 1 affects the outputs after edge SYNC_STAGES (battery select, reset) or SYNC_STAGES+1 (warning request).
- R2: With the enable high, a fall below the warning level gives `warn_irq` high for exactly one clock, and `warn_vec` always reads 8'h2B.
- R3: A warning crossing raises at most one request; while the supply stays below the warning level no further request appears, and a crossing seen with the enable low is consumed, so raising the enable afterwards gives no request until the supply goes back above the warning level and falls again.
- R4: During the warning stage alone, `core_reset` stays low and `ce_n_out`/`rw_n_out` equal `ce_n_in`/`rw_n_in`.
- R5: Whenever `core_reset` is high, every bit of `ce_n_out` and `rw_n_out` is 1.
- R6: After the synchronized minimum flag clears, `core_reset` stays high for exactly POR_CYCLES (default 21504) further clocks, so it falls after edge SYNC_STAGES+POR_CYCLES counted from the raw flag release.
- R7: A new dip below the minimum level during the hold restarts the full hold count from the next release.
- R8: `batt_sel` is high exactly while the synchronized battery flag is high, and a battery flag alone also asserts `core_reset` (ordered thresholds).
- R9: While `rst_n` is low the block treats the supply as fully collapsed: `core_reset`=1, `batt_sel`=1, `warn_irq`=0, bus controls forced to 1.
- R10: `warn_irq` is never high while `core_reset` is high; a warning crossing arriving with the minimum crossing raises no request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Asynchronous active-low reset (supply collapsed) |
| sup_below_warn | input | 1 | Raw flag: supply under warning level |
| sup_below_min | input | 1 | Raw flag: supply under minimum operating level |
| sup_below_batt | input | 1 | Raw flag: supply under battery switchover level |
| warn_irq_en | input | 1 | Enable for the warning interrupt |
| ce_n_in | input | NCE | Decoded chip enables from the core, active low |
| rw_n_in | input | 1 | Read/write strobe from the core |
| warn_irq | output | 1 | One-cycle warning interrupt request |
| warn_vec | output | 8 | Interrupt vector address of the warning request |
| core_reset | output | 1 | Internal reset to the core |
| ce_n_out | output | NCE | Chip enables to memory, forced high in reset |
| rw_n_out | output | 1 | Read/write strobe to memory, forced high in reset |
| batt_sel | output | 1 | Backup battery select |

## Verification
The sequencer is driven with a warning fall alone, a warning fall with the enable low followed by a late enable, a joint warning and minimum fall, a dip during the power-on hold, and a battery flag with no other flag. The lone warning fall separates the interrupt path from the reset path and shows the pulse width and latency; the disabled fall shows that a crossing is consumed and re-armed only by recovery. The joint fall and the dip show reset priority over the interrupt and the restart of the full hold, and the lone battery flag shows that the ordered-threshold assumption pulls reset with it.

// File: rtl/pwr_seq_ctl.sv
module pwr_seq_ctl #(
  parameter int         SYNC_STAGES = 2,
  parameter int         POR_CYCLES  = 21504,
  parameter int         NCE         = 4,
  parameter logic [7:0] WARN_VECTOR = 8'h2B
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           sup_below_warn,
  input  logic           sup_below_min,
  input  logic           sup_below_batt,
  input  logic           warn_irq_en,
  input  logic [NCE-1:0] ce_n_in,
  input  logic           rw_n_in,
  output logic           warn_irq,
  output logic [7:0]     warn_vec,
  output logic           core_reset,
  output logic [NCE-1:0] ce_n_out,
  output logic           rw_n_out,
  output logic           batt_sel
);
  localparam int CW = $clog2(POR_CYCLES + 1);

  logic [SYNC_STAGES-1:0] sync_warn, sync_min, sync_batt;
  logic                   warn_s, min_s, batt_s;
  logic                   min_eff, warn_eff;
  logic [CW-1:0]          hold_cnt;
  logic                   armed, irq_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sync_warn <= '1;
      sync_min  <= '1;
      sync_batt <= '1;
    end else begin
      sync_warn <= {sync_warn[SYNC_STAGES-2:0], sup_below_warn};
      sync_min  <= {sync_min[SYNC_STAGES-2:0],  sup_below_min};
      sync_batt <= {sync_batt[SYNC_STAGES-2:0], sup_below_batt};
    end

  assign warn_s   = sync_warn[SYNC_STAGES-1];
  assign min_s    = sync_min[SYNC_STAGES-1];
  assign batt_s   = sync_batt[SYNC_STAGES-1];
  assign min_eff  = min_s | batt_s;
  assign warn_eff = warn_s | min_eff;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)
      hold_cnt <= CW'(POR_CYCLES);
    else if (min_eff)
      hold_cnt <= CW'(POR_CYCLES);
    else if (hold_cnt != '0)
      hold_cnt <= hold_cnt - 1'b1;

  assign core_reset = min_eff | (hold_cnt != '0);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      armed <= 1'b0;
      irq_q <= 1'b0;
    end else begin
      irq_q <= warn_eff & armed & warn_irq_en & ~core_reset;
      armed <= ~warn_eff;
    end

  assign warn_irq = irq_q & ~core_reset;
  assign warn_vec = WARN_VECTOR;
  assign ce_n_out = core_reset ? '1 : ce_n_in;
  assign rw_n_out = core_reset | rw_n_in;
  assign batt_sel = batt_s;
endmodule

// File: rtl/pwr_seq_ctl_chk.sv
module pwr_seq_ctl_chk #(
  parameter int POR_CYCLES = 21504,
  parameter int NCE        = 4
) (
  input logic           clk,
  input logic           rst_n,
  input logic           warn_irq,
  input logic           core_reset,
  input logic [NCE-1:0] ce_n_out,
  input logic           rw_n_out,
  input logic           batt_sel,
  input logic           min_eff
);
  localparam int HW = $clog2(POR_CYCLES + 2);
  logic [HW-1:0] held;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                      held <= '0;
    else if (min_eff)                held <= '0;
    else if (core_reset)             held <= held + 1'b1;

  p_single_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
    warn_irq |=> !warn_irq);
  p_bus_forced_r5: assert property (@(posedge clk) disable iff (!rst_n)
    core_reset |-> (&ce_n_out && rw_n_out));
  p_hold_len_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(core_reset) |-> held == HW'(POR_CYCLES));
  p_batt_reset_r8: assert property (@(posedge clk) disable iff (!rst_n)
    batt_sel |-> core_reset);
  p_no_irq_reset_r10: assert property (@(posedge clk) disable iff (!rst_n)
    core_reset |-> !warn_irq);
endmodule

bind pwr_seq_ctl pwr_seq_ctl_chk #(.POR_CYCLES(POR_CYCLES), .NCE(NCE)) u_chk (
  .clk(clk), .rst_n(rst_n), .warn_irq(warn_irq), .core_reset(core_reset),
  .ce_n_out(ce_n_out), .rw_n_out(rw_n_out), .batt_sel(batt_sel), .min_eff(min_eff)
);

// File: tb/sim_pwr_seq_ctl.sv
`timescale 1ns/1ps
module sim_pwr_seq_ctl;
  localparam int S = 2, POR = 21504, NCE = 4;

  logic clk = 0, rst_n = 0;
  logic bw = 1, bm = 1, bb = 1, en = 1;
  logic [NCE-1:0] ce_in = 4'b1010;
  logic rw_in = 0;
  logic warn_irq, core_reset, rw_n_out, batt_sel;
  logic [7:0] warn_vec;
  logic [NCE-1:0] ce_n_out;
  int total = 0, bad = 0;

  always #2.5 clk = ~clk;

  pwr_seq_ctl u0 (
    .clk(clk), .rst_n(rst_n), .sup_below_warn(bw), .sup_below_min(bm),
    .sup_below_batt(bb), .warn_irq_en(en), .ce_n_in(ce_in), .rw_n_in(rw_in),
    .warn_irq(warn_irq), .warn_vec(warn_vec), .core_reset(core_reset),
    .ce_n_out(ce_n_out), .rw_n_out(rw_n_out), .batt_sel(batt_sel)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // Count edges (sampled at negedge) until core_reset falls.
  task automatic wait_release(output int n);
    n = 0;
    while (core_reset && n < POR + 100) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic t_reset();
    step(3);
    chk(core_reset == 1, "R9 reset", core_reset, 1);
    chk(batt_sel == 1, "R9 batt", batt_sel, 1);
    chk(warn_irq == 0, "R9 irq", warn_irq, 0);
    chk(ce_n_out == '1 && rw_n_out == 1, "R9 bus", int'(ce_n_out), 15);
  endtask

  task automatic t_powerup();
    int n;
    bw = 0; bm = 0; bb = 0;
    rst_n = 1;
    wait_release(n);
    chk(n == S + POR, "R6 hold", n, S + POR);
    chk(batt_sel == 0, "R1 batt clear", batt_sel, 0);
    chk(ce_n_out == ce_in && rw_n_out == rw_in, "R4 passthrough", int'(ce_n_out), int'(ce_in));
    chk(warn_vec == 8'h2B, "R2 vector", warn_vec, 'h2B);
  endtask

  task automatic t_warn();
    int n = 0, pulses = 0;
    en = 1;
    bw = 1;
    while (!warn_irq && n < 20) begin @(negedge clk); n++; end
    chk(n == S + 1, "R1 warn latency", n, S + 1);
    chk(warn_irq == 1, "R2 pulse", warn_irq, 1);
    chk(core_reset == 0, "R4 no reset", core_reset, 0);
    chk(ce_n_out == ce_in && rw_n_out == rw_in, "R4 bus", int'(ce_n_out), int'(ce_in));
    step(1);
    chk(warn_irq == 0, "R2 one cycle", warn_irq, 0);
    for (int i = 0; i < 20; i++) begin step(1); pulses += warn_irq; end
    chk(pulses == 0, "R3 no repeat", pulses, 0);
    bw = 0; step(5);
    bw = 1; pulses = 0;
    for (int i = 0; i < 8; i++) begin step(1); pulses += warn_irq; end
    chk(pulses == 1, "R3 rearm", pulses, 1);
    bw = 0; step(5);
  endtask

  task automatic t_warn_dis();
    int pulses = 0;
    en = 0; bw = 1;
    for (int i = 0; i < 8; i++) begin step(1); pulses += warn_irq; end
    en = 1;
    for (int i = 0; i < 8; i++) begin step(1); pulses += warn_irq; end
    chk(pulses == 0, "R3 consumed", pulses, 0);
    bw = 0; step(5);
    bw = 1; pulses = 0;
    for (int i = 0; i < 8; i++) begin step(1); pulses += warn_irq; end
    chk(pulses == 1, "R3 after recovery", pulses, 1);
    bw = 0; step(5);
  endtask

  task automatic t_min_dip();
    int pulses = 0, n;
    bw = 1; bm = 1;
    step(S);
    chk(core_reset == 1, "R1 min latency", core_reset, 1);
    chk(ce_n_out == '1 && rw_n_out == 1, "R5 forced", int'(ce_n_out), 15);
    for (int i = 0; i < 10; i++) begin step(1); pulses += warn_irq; end
    chk(pulses == 0, "R10 no irq", pulses, 0);
    bm = 0; bw = 0;
    step(1000);
    chk(core_reset == 1, "R6 still held", core_reset, 1);
    bm = 1; step(4); bm = 0;
    wait_release(n);
    chk(n == S + POR, "R7 restart", n, S + POR);
  endtask

  task automatic t_batt();
    int n;
    bb = 1;
    step(S - 1);
    chk(batt_sel == 0, "R1 batt early", batt_sel, 0);
    step(1);
    chk(batt_sel == 1, "R8 batt sel", batt_sel, 1);
    chk(core_reset == 1, "R8 batt reset", core_reset, 1);
    bb = 0;
    step(S);
    chk(batt_sel == 0, "R8 batt clear", batt_sel, 0);
    wait_release(n);
    chk(n == POR, "R6 hold after batt", n, POR);
  endtask

  initial begin
    fork
      begin
        t_reset();
        t_powerup();
        t_warn();
        t_warn_dis();
        t_min_dip();
        t_batt();
      end
      begin
        repeat (190000) @(posedge clk);
        chk(0, "watchdog", 0, 1);
      end
    join_any
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule